// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects interrupt requests from a set of devices. Each device has its own request input and its own grant output, so a device's priority comes from its index and not from where it sits on a shared line. Among the pending requests, the controller picks the one with the lowest index. It raises a single pending flag toward the processor. When the processor acknowledges, the controller sends a one-cycle grant to the selected device and records that device as the level in service.

While a level is in service, only a strictly higher-priority request can raise the pending flag again. When the processor acknowledges such a request, the controller pushes the interrupted level onto an internal stack and the new device becomes the level in service. A request of equal or lower priority waits until its turn comes. An end-of-service strobe retires the current level and pops the most recent saved level back into service. When the stack is empty, the strobe returns the controller to idle.

Top module: `nest_irq_ctrl`

## Requirements
- R1: While reset is held and right after it, every grant line is low, `busy` is low and `irq_pending` is low.
- R2: When idle, `irq_pending` is high in the same cycle that any request line is high. The selected device is the lowest-index requester, so device 0 has the highest priority.
- R3: When `cpu_ack` is high in a cycle where `irq_pending` is high and `eos` is low, the request is accepted. In the next cycle, exactly one grant bit (bit i for device i) is high for one cycle. `busy` goes high and `level` shows the granted index in binary.
- R4: `cpu_ack` in a cycle where `irq_pending` is low has no effect. No grant is issued and `busy`/`level` stay unchanged.
- R5: While a level L is in service, requests with an index greater than or equal to L do not raise `irq_pending`, and an acknowledge does not grant them.
- R6: While a level L is in service, a request with an index below L raises `irq_pending`. Accepting it grants that device, makes it the new `level`, and saves L on the stack.
- R7: `eos` while busy retires the current level. If any level is saved, the most recently saved one becomes `level` in the next cycle. Otherwise `busy` falls.
- R8: `eos` while idle is ignored: no grant is issued and `busy` stays low.
- R9: Requests are level-sensitive. A request withdrawn before acknowledge leaves nothing behind, and a later acknowledge with no request high grants nothing.
- R10: When `eos` and `cpu_ack` are high in the same cycle, only the end of service takes effect and the acknowledge is ignored.
- R11: Nesting reaches every device, up to N levels deep, with no stack overflow. Unwinding restores the levels in the reverse order of preemption.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_req | input | N_DEV | Level-sensitive request, one bit per device |
| dev_grant | output | N_DEV | One-cycle grant pulse, one bit per device |
| irq_pending | output | 1 | A request eligible for service is present |
| cpu_ack | input | 1 | Processor accepts the pending interrupt |
| eos | input | 1 | Processor ends service of the current level |
| busy | output | 1 | A level is in service |
| level | output | $clog2(N_DEV) | Index of the device in service |

## Verification
On every cycle, the assertions check the following: grants are one-hot or zero, and each grant follows an accepted acknowledge. Each preemption lowers the level index, and the save stack never overflows or underflows. Only the bench's scenarios can show the order in which saved levels come back, the dropping of withdrawn requests, and the precedence of end of service over a simultaneous acknowledge. The bench shows these by comparing the outputs with a behavioural model on every cycle, across a full eight-deep nest and unwind.

// File: rtl/nest_irq_pkg.sv
package nest_irq_pkg;

    typedef struct packed {
        logic       hit;
        logic [7:0] idx;
    } pick_t;

    function automatic logic [7:0] clamp_idx(input int unsigned i);
        return 8'(i);
    endfunction

endpackage

// File: rtl/nest_irq_pick.sv
module nest_irq_pick #(
    parameter int N_DEV = 8,
    localparam int IDW = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
    input  logic [N_DEV-1:0] req,
    output logic             hit,
    output logic [IDW-1:0]   idx
);
    import nest_irq_pkg::*;

    pick_t sel;

    always_comb begin
        sel = '0;
        for (int i = N_DEV - 1; i >= 0; i--) begin
            if (req[i]) begin
                sel.hit = 1'b1;
                sel.idx = clamp_idx(i);
            end
        end
    end

    assign hit = sel.hit;
    assign idx = sel.idx[IDW-1:0];
endmodule

// File: rtl/nest_irq_stack.sv
module nest_irq_stack #(
    parameter int N_DEV = 8,
    localparam int IDW = (N_DEV > 1) ? $clog2(N_DEV) : 1,
    localparam int SPW = $clog2(N_DEV + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           push,
    input  logic           pop,
    input  logic [IDW-1:0] din,
    output logic [IDW-1:0] top,
    output logic           empty,
    output logic           full
);
    logic [IDW-1:0] mem [N_DEV];
    logic [SPW-1:0] sp_q;

    assign empty = (sp_q == '0);
    assign full  = (sp_q == SPW'(N_DEV));
    assign top   = empty ? '0 : mem[sp_q - 1'b1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= '0;
        end else if (push) begin
            mem[sp_q[IDW-1:0]] <= din;
            sp_q <= sp_q + 1'b1;
        end else if (pop) begin
            sp_q <= sp_q - 1'b1;
        end
    end

    // R11
    stack_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    // R7
    stack_no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
    parameter int N_DEV = 8,
    localparam int IDW = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_DEV-1:0] dev_req,
    output logic [N_DEV-1:0] dev_grant,
    output logic             irq_pending,
    input  logic             cpu_ack,
    input  logic             eos,
    output logic             busy,
    output logic [IDW-1:0]   level
);
    logic           cand_hit;
    logic [IDW-1:0] cand_idx;
    logic           act_q;
    logic [IDW-1:0] lvl_q;
    logic [N_DEV-1:0] grant_q;
    logic           accept, retire, do_push, do_pop;
    logic [IDW-1:0] saved_lvl;
    logic           stk_empty, stk_full;

    nest_irq_pick #(.N_DEV(N_DEV)) u_pick (
        .req (dev_req),
        .hit (cand_hit),
        .idx (cand_idx)
    );

    always_comb begin
        irq_pending = cand_hit && (!act_q || (cand_idx < lvl_q));
        accept      = cpu_ack && irq_pending && !eos;
        retire      = eos && act_q;
        do_push     = accept && act_q;
        do_pop      = retire && !stk_empty;
    end

    nest_irq_stack #(.N_DEV(N_DEV)) u_stack (
        .clk   (clk),
        .rst   (rst),
        .push  (do_push),
        .pop   (do_pop),
        .din   (lvl_q),
        .top   (saved_lvl),
        .empty (stk_empty),
        .full  (stk_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= 1'b0;
            lvl_q   <= '0;
            grant_q <= '0;
        end else begin
            grant_q <= '0;
            if (accept) begin
                act_q   <= 1'b1;
                lvl_q   <= cand_idx;
                grant_q <= N_DEV'(1) << cand_idx;
            end else if (retire) begin
                if (!stk_empty) lvl_q <= saved_lvl;
                else            act_q <= 1'b0;
            end
        end
    end

    assign dev_grant = grant_q;
    assign busy      = act_q;
    assign level     = lvl_q;

    // R3
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dev_grant));
    // R3
    grant_follows_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_ack && irq_pending && !eos) |=> (dev_grant != '0) && busy);
    // R6
    preempt_lowers_level_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_ack && irq_pending && !eos && busy) |=> (level < $past(level)));
    // R8
    idle_eos_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (eos && !busy) |=> (!busy && dev_grant == '0));
    // R5
    no_pending_at_or_below_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && irq_pending) |-> (cand_idx < level));
endmodule

// File: tb/nest_irq_ctrl_test.sv
module nest_irq_ctrl_test;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] dev_req = '0;
    logic         cpu_ack = 1'b0;
    logic         eos = 1'b0;
    logic [N-1:0] dev_grant;
    logic         irq_pending;
    logic         busy;
    logic [2:0]   level;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int m_stk[$];
    bit m_act = 0;
    int m_lvl = 0;

    always #5 clk = ~clk;

    nest_irq_ctrl #(.N_DEV(N)) uut (
        .clk(clk), .rst(rst), .dev_req(dev_req), .dev_grant(dev_grant),
        .irq_pending(irq_pending), .cpu_ack(cpu_ack), .eos(eos),
        .busy(busy), .level(level)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic [N-1:0] r, input logic a, input logic e,
                        input string tag);
        int idx;
        bit pend, acc, ret;
        int exp_grant;
        dev_req = r; cpu_ack = a; eos = e;
        #1;
        idx = -1;
        for (int i = N - 1; i >= 0; i--) if (r[i]) idx = i;
        pend = (idx >= 0) && (!m_act || idx < m_lvl);
        chk({tag, " pending"}, irq_pending, pend);
        acc = a && pend && !e;
        ret = e && m_act;
        exp_grant = 0;
        if (acc) begin
            if (m_act) m_stk.push_back(m_lvl);
            m_act = 1; m_lvl = idx;
            exp_grant = 1 << idx;
        end else if (ret) begin
            if (m_stk.size() > 0) m_lvl = m_stk.pop_back();
            else m_act = 0;
        end
        @(posedge clk); #1;
        chk({tag, " grant"}, dev_grant, exp_grant);
        chk({tag, " busy"}, busy, m_act);
        if (m_act) chk({tag, " level"}, level, m_lvl);
        @(negedge clk);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 state during reset
        chk("R1 grant", dev_grant, 0);
        chk("R1 busy", busy, 0);
        chk("R1 pending", irq_pending, 0);
        @(negedge clk);
        rst = 1'b0;
        step('0, 0, 0, "R1 idle");
        // R2 lowest index wins, no ack keeps state
        step(8'b0010_0100, 0, 0, "R2 pick");
        // R4 ack without pending ignored
        step('0, 1, 0, "R4 ack idle");
        // R3 accept device 2
        step(8'b0010_0100, 1, 0, "R3 accept");
        step(8'b0010_0100, 0, 0, "R3 pulse");
        // R5 equal and lower priority held
        step(8'b0010_0100, 1, 0, "R5 held");
        step(8'b1000_0000, 1, 0, "R5 lower");
        // R6 device 0 preempts
        step(8'b0000_0001, 1, 0, "R6 preempt");
        // R7 unwind
        step('0, 0, 1, "R7 pop");
        step('0, 0, 1, "R7 last");
        // R8 eos while idle
        step('0, 0, 1, "R8 idle eos");
        // R9 withdrawn request
        step(8'b0000_1000, 0, 0, "R9 raise");
        step('0, 0, 0, "R9 drop");
        step('0, 1, 0, "R9 late ack");
        // R10 eos beats ack
        step(8'b0001_0000, 1, 0, "R10 setup");
        step(8'b0000_0010, 1, 1, "R10 both");
        step(8'b0000_0010, 0, 0, "R10 after");
        // R11 full nest down to device 0
        for (int d = N - 1; d >= 0; d--)
            step(N'(1) << d, 1, 0, "R11 nest");
        for (int k = 0; k < N; k++)
            step('0, 0, 1, "R11 unwind");
        step('0, 0, 0, "R11 idle");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule